// File: doc/BRIEF.md
# Pattern-Trigger Capture Unit

This block watches a 16-channel digital probe bus on the system clock and starts a recording when every channel meets its own programmed condition in the same sample. A condition can require a steady low or high level, a rising or falling transition between two consecutive samples, or nothing at all. Once the pattern is seen, the unit stores the triggering sample and the 63 samples after it into an internal 64-entry buffer, raises a completion flag, and lets the buffer be read by index.

Software writes one channel condition per cycle, selects between single-shot and free-running behaviour, and issues arm and stop pulses. The controller has four states. IDLE waits for an arm pulse (transition *arm*). ARMED evaluates the pattern every cycle (transition *trigger* to CAPTURE). CAPTURE writes one sample per cycle (transition *fill-end* to DONE in single-shot mode, or *rearm* back to ARMED in free-running mode). DONE freezes the buffer until an arm pulse (transition *rearm-by-software*). A stop pulse takes any state to IDLE (transition *halt*). At a nominal 27 MHz sample rate one sample spans roughly 37 ns, so a full buffer covers about 2.4 us.

Top module: `pat_capture`

## Requirements
- R1: Each channel holds a 3-bit condition written through `cond_we`/`cond_ch`/`cond_code`: 0 any value, 1 low, 2 high, 3 rising (previous sample 0, current 1), 4 falling (previous 1, current 0); codes 5, 6 and 7 behave as code 0.
- R2: A trigger happens only in a cycle where all 16 channels satisfy their conditions on the same probe sample; that sample becomes buffer entry 0.
- R3: Edge conditions compare each sample with the one sampled one clock earlier; after reset no edge condition can be satisfied by the first sample taken.
- R4: After a trigger on sample T, buffer entry i (0..63) holds sample T+i, `busy` is high while the 64 entries are written, and `done` rises 64 clocks after the clock that took sample T.
- R5: Single-shot mode (`run_mode`=0): after the buffer fills, the unit stays with `done`=1 and `armed`=0, ignores matching patterns and keeps the buffer unchanged until the next arm pulse.
- R6: Free-running mode (`run_mode`=1): after the buffer fills, the unit returns to ARMED at once with `done`=1, and the next matching sample starts a new capture that clears `done` and later sets it again.
- R7: A stop pulse sends the unit to IDLE from any state on the next clock and leaves the buffer and `done` as they were; stop wins over arm and trigger in the same cycle.
- R8: An arm pulse in IDLE or DONE enters ARMED and clears `done`; an arm pulse during CAPTURE has no effect.
- R9: Synchronous reset leaves the unit in IDLE with `done`=0, all conditions set to code 0 and the sample history emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| rst | input | 1 | Synchronous reset, active high |
| probe | input | 16 | Probe channels sampled every clock |
| cond_we | input | 1 | Write strobe for one channel condition |
| cond_ch | input | 4 | Channel whose condition is written |
| cond_code | input | 3 | Condition code (see R1) |
| run_mode | input | 1 | 1 free-running, 0 single-shot |
| arm | input | 1 | Arm pulse |
| stop | input | 1 | Stop pulse |
| rd_idx | input | 6 | Buffer entry to read |
| rd_data | output | 16 | Buffer entry selected by rd_idx |
| armed | output | 1 | Unit is waiting for the pattern |
| busy | output | 1 | Unit is filling the buffer |
| done | output | 1 | Buffer holds a complete capture |

## Verification
The two functions that can meet in one cycle are the end of a buffer fill and the start of the next capture in free-running mode: the unit re-enters ARMED on the clock that writes entry 63, so the very next sample may already trigger. The bench drives a Gray-coded sweep whose patterns repeat quickly, lets a second capture follow the first without gaps, and judges the exact clock at which `done` falls and rises again along with all 64 entries of each capture against values computed from the sweep formula. Stop colliding with arm, and arm colliding with an ongoing fill, are provoked in the same way and judged on `armed`, `busy` and `done`.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
    localparam int COND_W = 3;

    localparam logic [COND_W-1:0] C_ANY  = 3'd0;
    localparam logic [COND_W-1:0] C_LOW  = 3'd1;
    localparam logic [COND_W-1:0] C_HIGH = 3'd2;
    localparam logic [COND_W-1:0] C_RISE = 3'd3;
    localparam logic [COND_W-1:0] C_FALL = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CAPTURE,
        ST_DONE
    } cap_state_e;
endpackage

// File: rtl/pc_sampler.sv
`timescale 1ns/1ps
// Registers the probe bus and keeps the previous sample for edge checks.
module pc_sampler #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] probe,
    output logic [NCH-1:0] cur,
    output logic [NCH-1:0] prev,
    output logic           lvl_ok,
    output logic           edge_ok
);
    logic [1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            prev   <= '0;
            fill_q <= '0;
        end else begin
            cur  <= probe;
            prev <= cur;
            if (fill_q != 2'd2) fill_q <= fill_q + 2'd1;
        end
    end

    assign lvl_ok  = (fill_q != 2'd0);
    assign edge_ok = (fill_q == 2'd2);

    // R3: history becomes usable for edges only after a level sample exists
    a_r3_history_order: assert property (@(posedge clk) disable iff (rst)
        edge_ok |-> $past(lvl_ok));
endmodule

// File: rtl/pc_chan_match.sv
`timescale 1ns/1ps
// Evaluates one channel's condition on the current and previous sample.
module pc_chan_match
    import pc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [COND_W-1:0] code,
    input  logic              cur,
    input  logic              prev,
    input  logic              lvl_ok,
    input  logic              edge_ok,
    output logic              hit
);
    always_comb begin
        unique case (code)
            C_LOW:   hit = lvl_ok && !cur;
            C_HIGH:  hit = lvl_ok && cur;
            C_RISE:  hit = edge_ok && !prev && cur;
            C_FALL:  hit = edge_ok && prev && !cur;
            default: hit = 1'b1;
        endcase
    end

    // R3: an edge condition cannot hit before two samples exist
    a_r3_no_early_edge: assert property (@(posedge clk) disable iff (rst)
        (!edge_ok && (code == C_RISE || code == C_FALL)) |-> !hit);
endmodule

// File: rtl/pc_buffer.sv
`timescale 1ns/1ps
// Capture storage: one write port, one asynchronous read port.
module pc_buffer #(
    parameter int W     = 16,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pat_capture.sv
`timescale 1ns/1ps
// Pattern-triggered capture: per-channel conditions, trigger FSM, buffer.
module pat_capture
    import pc_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int DEPTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NCH-1:0]           probe,
    input  logic                     cond_we,
    input  logic [$clog2(NCH)-1:0]   cond_ch,
    input  logic [COND_W-1:0]        cond_code,
    input  logic                     run_mode,
    input  logic                     arm,
    input  logic                     stop,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [NCH-1:0]           rd_data,
    output logic                     armed,
    output logic                     busy,
    output logic                     done
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [NCH-1:0] cur_s, prev_s, hits;
    logic           lvl_ok, edge_ok, all_hit;

    pc_sampler #(.NCH(NCH)) u_smp (
        .clk(clk), .rst(rst), .probe(probe),
        .cur(cur_s), .prev(prev_s), .lvl_ok(lvl_ok), .edge_ok(edge_ok)
    );

    // condition table
    logic [COND_W-1:0] cond_q [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) cond_q[i] <= C_ANY;
        end else if (cond_we) begin
            cond_q[cond_ch] <= cond_code;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pc_chan_match u_m (
            .clk(clk), .rst(rst), .code(cond_q[g]),
            .cur(cur_s[g]), .prev(prev_s[g]),
            .lvl_ok(lvl_ok), .edge_ok(edge_ok), .hit(hits[g])
        );
    end

    assign all_hit = &hits;

    // controller
    cap_state_e    st, nxt;
    logic [AW-1:0] widx, widx_nxt, waddr;
    logic          done_q, we, cap_end, done_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            widx   <= '0;
            done_q <= 1'b0;
        end else begin
            st   <= nxt;
            widx <= widx_nxt;
            if (cap_end)       done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
        end
    end

    always_comb begin
        nxt      = st;
        widx_nxt = widx;
        we       = 1'b0;
        waddr    = widx;
        cap_end  = 1'b0;
        done_clr = 1'b0;
        unique case (st)
            ST_IDLE, ST_DONE: begin
                if (arm) begin
                    nxt      = ST_ARMED;
                    done_clr = 1'b1;
                end
            end
            ST_ARMED: begin
                if (all_hit) begin
                    nxt      = ST_CAPTURE;
                    we       = 1'b1;
                    waddr    = '0;
                    widx_nxt = AW'(1);
                    done_clr = 1'b1;
                end
            end
            ST_CAPTURE: begin
                we       = 1'b1;
                widx_nxt = widx + AW'(1);
                if (widx == LAST) begin
                    cap_end = 1'b1;
                    nxt     = run_mode ? ST_ARMED : ST_DONE;
                end
            end
        endcase
        if (stop) begin
            nxt      = ST_IDLE;
            widx_nxt = widx;
            we       = 1'b0;
            cap_end  = 1'b0;
            done_clr = 1'b0;
        end
    end

    assign armed = (st == ST_ARMED);
    assign busy  = (st == ST_CAPTURE);
    assign done  = done_q;

    pc_buffer #(.W(NCH), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .we(we), .waddr(waddr), .wdata(cur_s),
        .raddr(rd_idx), .rdata(rd_data)
    );

    // R7: stop always lands in IDLE
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop |=> (st == ST_IDLE));
    // R2: a full match while armed starts the capture
    a_r2_trigger: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ARMED && all_hit && !stop) |=> (st == ST_CAPTURE && !done));
    // R4: completion is only flagged out of a fill
    a_r4_done_after_fill: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(st) == ST_CAPTURE));
    // R5: single-shot hold
    a_r5_single_hold: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DONE && !arm && !stop) |=> (st == ST_DONE && done));
    // R6: free-running rearm right after the last write
    a_r6_run_rearm: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAPTURE && widx == LAST && run_mode && !stop) |=> (st == ST_ARMED && done));
    // R8: arm during a fill does not disturb it
    a_r8_fill_continues: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CAPTURE && widx != LAST && !stop) |=> (st == ST_CAPTURE && widx == $past(widx) + AW'(1)));
endmodule

// File: tb/pat_capture_bench.sv
`timescale 1ns/1ps
module pat_capture_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] probe;
    logic        cond_we = 1'b0;
    logic [3:0]  cond_ch = '0;
    logic [2:0]  cond_code = '0;
    logic        run_mode = 1'b0;
    logic        arm = 1'b0;
    logic        stop = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        armed, busy, done;

    int errors = 0;
    int checks = 0;
    int unsigned kcnt = 0;
    int bc [16];
    int unsigned edge_min = 0;

    always #2.5 clk = ~clk;

    pat_capture u_pat_capture (
        .clk(clk), .rst(rst), .probe(probe), .cond_we(cond_we), .cond_ch(cond_ch),
        .cond_code(cond_code), .run_mode(run_mode), .arm(arm), .stop(stop),
        .rd_idx(rd_idx), .rd_data(rd_data), .armed(armed), .busy(busy), .done(done)
    );

    // sample m is the Gray code of m
    function automatic logic [15:0] pv(input int unsigned m);
        int unsigned g;
        g = m ^ (m >> 1);
        return g[15:0];
    endfunction

    initial probe = pv(1);
    always @(posedge clk) kcnt <= kcnt + 1;
    always @(negedge clk) probe <= pv(kcnt + 1);

    function automatic bit pat_ok(input int unsigned m);
        logic [15:0] c, p;
        bit ok;
        c = pv(m);
        p = pv(m - 1);
        ok = 1'b1;
        for (int ch = 0; ch < 16; ch++) begin
            case (bc[ch])
                1: ok = ok && (m + 1 >= edge_min) && !c[ch];
                2: ok = ok && (m + 1 >= edge_min) && c[ch];
                3: ok = ok && (m >= edge_min) && !p[ch] && c[ch];
                4: ok = ok && (m >= edge_min) && p[ch] && !c[ch];
                default: ok = ok;
            endcase
        end
        return ok;
    endfunction

    function automatic int unsigned find_trig(input int unsigned a);
        for (int unsigned m = a; m < a + 150000; m++)
            if (pat_ok(m)) return m;
        return a + 150000;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cond(input int ch, input int code);
        cond_we = 1'b1; cond_ch = 4'(ch); cond_code = 3'(code);
        bc[ch] = code;
        @(negedge clk);
        cond_we = 1'b0;
    endtask

    task automatic clear_conds();
        for (int ch = 0; ch < 16; ch++) set_cond(ch, 0);
    endtask

    task automatic do_arm(output int unsigned a);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        a = kcnt;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    // read all 64 entries within half a clock
    task automatic verify_buf(input int unsigned t, input string tag);
        bit ok;
        int bad_i;
        logic [15:0] bad_v;
        ok = 1'b1; bad_i = 0; bad_v = '0;
        for (int i = 0; i < 64; i++) begin
            rd_idx = 6'(i);
            #0.02;
            if (ok && rd_data !== pv(t + i)) begin
                ok = 1'b0; bad_i = i; bad_v = rd_data;
            end
        end
        chk(ok, {tag, " buffer entry"}, bad_v, pv(t + bad_i));
    endtask

    // waits from arm index a until the fill ends; checks timing and contents
    task automatic expect_capture(input int unsigned a, input string tag, output int unsigned t);
        t = find_trig(a);
        while (kcnt < t + 63) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0, {tag, " filling before last entry"}, {busy, done}, 2);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, {tag, " done after 64 samples"}, {busy, done}, 1);
        verify_buf(t, tag);
    endtask

    initial begin
        int unsigned a, t, t2, r;
        int c;
        for (int ch = 0; ch < 16; ch++) bc[ch] = 0;

        // R9: reset state
        repeat (4) @(negedge clk);
        chk(armed == 0 && busy == 0 && done == 0, "R9 reset outputs", {armed, busy, done}, 0);

        // R3: edge cannot use the cleared history after reset
        r = kcnt;
        c = 0;
        for (int b = 15; b >= 0; b--) if (pv(r + 1)[b]) c = b;
        rst = 1'b0;
        cond_we = 1'b1; cond_ch = 4'(c); cond_code = 3'd3; bc[c] = 3;
        arm = 1'b1;
        @(negedge clk);
        cond_we = 1'b0; arm = 1'b0; a = kcnt;
        edge_min = r + 2;
        expect_capture(a, "R3 post-reset edge", t);
        chk(t != a, "R3 first sample not an edge", t, a + 1);
        edge_min = 0;

        // R5: single-shot hold while the pattern keeps matching
        set_cond(c, 0);
        repeat (150) @(negedge clk);
        chk(done == 1 && armed == 0 && busy == 0, "R5 frozen", {armed, busy, done}, 1);
        verify_buf(t, "R5 held");

        // R1: unused codes act as any value
        for (int ch = 0; ch < 16; ch++) set_cond(ch, 5 + (ch % 3));
        do_arm(a);
        chk(done == 0 && armed == 1, "R8 arm clears done", {armed, done}, 2);
        expect_capture(a, "R1 unused codes", t);
        chk(t == a, "R1 immediate trigger", t, a);
        clear_conds();

        // R1/R3: rising and falling sweep per channel
        for (int ch = 0; ch < 11; ch++) begin
            for (int code = 3; code <= 4; code++) begin
                set_cond(ch, code);
                do_arm(a);
                expect_capture(a, (code == 3) ? "R1 rising sweep" : "R1 falling sweep", t);
                chk(pv(t)[ch] == (code == 3) && pv(t - 1)[ch] == (code == 4),
                    "R3 edge at trigger", pv(t)[ch], code == 3);
            end
            set_cond(ch, 0);
        end

        // R2: all channels must agree in one sample
        set_cond(15, 2); set_cond(14, 1); set_cond(3, 3);
        do_arm(a);
        expect_capture(a, "R2 mixed levels and edge", t);
        clear_conds();
        set_cond(0, 1); set_cond(1, 2); set_cond(2, 4);
        do_arm(a);
        expect_capture(a, "R2 low high falling", t);
        clear_conds();

        // R8: arm during the fill is ignored
        set_cond(0, 3);
        do_arm(a);
        t = find_trig(a);
        while (kcnt < t + 10) @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        chk(busy == 1, "R8 fill continues after arm", busy, 1);
        while (kcnt < t + 64) @(negedge clk);
        chk(done == 1 && armed == 0, "R8 fill ends in hold", {armed, done}, 1);
        verify_buf(t, "R8 arm during fill");

        // R6: free-running back-to-back captures
        run_mode = 1'b1;
        do_arm(a);
        expect_capture(a, "R6 first run capture", t);
        chk(armed == 1 && done == 1, "R6 rearmed with done kept", {armed, done}, 3);
        expect_capture(t + 64, "R6 second run capture", t2);
        chk(t2 > t + 63, "R6 second trigger after first", t2, t + 64);

        // R7: stop holds buffer and done
        pulse_stop();
        chk(armed == 0 && busy == 0 && done == 1, "R7 stop to idle", {armed, busy, done}, 1);
        repeat (100) @(negedge clk);
        chk(done == 1 && armed == 0, "R7 idle holds", {armed, done}, 1);
        verify_buf(t2, "R7 held after stop");
        run_mode = 1'b0;

        // R7: stop beats arm in the same cycle
        arm = 1'b1; stop = 1'b1;
        @(negedge clk);
        arm = 1'b0; stop = 1'b0;
        chk(armed == 0 && done == 1, "R7 stop over arm", {armed, done}, 1);

        // R7: stop during a fill
        do_arm(a);
        t = find_trig(a);
        while (kcnt < t + 5) @(negedge clk);
        chk(busy == 1, "R7 filling before stop", busy, 1);
        pulse_stop();
        chk(busy == 0 && armed == 0 && done == 0, "R7 stop mid fill", {armed, busy, done}, 0);

        // R9: mid-run reset clears conditions
        set_cond(5, 2);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(armed == 0 && busy == 0 && done == 0, "R9 reset again", {armed, busy, done}, 0);
        rst = 1'b0;
        for (int ch = 0; ch < 16; ch++) bc[ch] = 0;
        @(negedge clk);
        do_arm(a);
        expect_capture(a, "R9 conditions cleared", t);
        chk(t == a, "R9 any-value trigger", t, a);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", kcnt);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule